// File: doc/BRIEF.md
# Translation Table Update Engine

This block maintains one I/O address translation table on behalf of software commands. A command names a table, a bus address inside the table's window and either an entry value or the address of a list of values in system memory. The engine turns the bus address into an entry index and then writes or reads that entry through a synchronous table port. Four maintenance operations exist: store one entry, read one entry back, repeat one value over a run of consecutive pages, and copy a run of entries from a list in memory. Two further commands open the window, setting its base offset, page size and entry count, and close it again.

Each entry that is written is also announced on a notification output. The notification carries the page-aligned window offset, the translated page address, the in-page address mask and the two access permission bits, so that cached translations elsewhere in the system can be refreshed. Commands run one at a time. While a multi-page command is in progress the engine is busy and the command port is held off. Every accepted command ends with exactly one response that carries a status and, for a read, the entry value.

Top module: `xlt_update_engine`

## Requirements
- R1: A command whose identifier has any of bits 63:32 set, or whose bits 31:0 differ from the TABLE_ID parameter, gets status 1 (parameter error) and changes no entry.
- R2: Opcode 0 (store) aligns the bus address down to the page size, takes index = (aligned address - window base) >> page shift, writes the value there and responds with status 0 one cycle after acceptance.
- R3: An index at or beyond the entry count, including any index reached while the window is closed or for an address below the base, gets status 1 and no table write.
- R4: Every entry write produces a notification in the same cycle as the table write. It carries the page-aligned window offset, the value with its in-page bits cleared, the in-page mask, and perm = value bits 1:0 (0 none, 1 read-only, 2 write-only, 3 read-write).
- R5: Opcode 1 (read) returns the stored entry with status 0 three cycles after acceptance. An out-of-range index returns status 1 and value 0.
- R6: Opcode 2 (fill) rejects a page count greater than the entry count with no writes. Otherwise it writes the same value to consecutive pages and advances the address by one page per entry. A count of 0 succeeds.
- R7: Opcode 3 (list) rejects a page count above 512, or a list address with any of bits 11:0 set, with status 1 and no fetch.
- R8: For the list command, entry i is fetched from list address + 8*i with at most one read outstanding. Byte lane k of mem_rsp_data holds the byte at fetch address + k, and lane 0 is the most significant byte of the entry.
- R9: A fill or list command stops at the first entry whose index is out of range and returns status 1. The entries written before that point stay written.
- R10: Opcode 4 (open) loads base = cmd_addr, page shift = cmd_value[5:0] and entry count = cmd_count (1..MAX_ENTRIES). An open while the window is already open returns status 0 and changes nothing. Opcode 5 (close) sets base, shift and count to zero.
- R11: While a command is in progress, busy is high and cmd_ready is low. Each accepted command produces exactly one response, and the response comes when busy is low.
- R12: After reset the window is closed, busy is low, cmd_ready is high and no response, write, read, fetch or notification is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | 0 store, 1 read, 2 fill, 3 list, 4 open, 5 close |
| cmd_id | input | 64 | Table identifier |
| cmd_addr | input | 64 | Bus address, list address (list) or window base (open) |
| cmd_value | input | 64 | Entry value, or page shift in bits 5:0 (open) |
| cmd_count | input | 32 | Page count, or entry count (open) |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | 0 success, 1 parameter error |
| rsp_value | output | 64 | Entry value for read, else 0 |
| busy | output | 1 | Command in progress |
| mem_req_valid | output | 1 | List word read request pulse |
| mem_req_addr | output | 64 | List word byte address |
| mem_rsp_valid | input | 1 | List word returned |
| mem_rsp_data | input | 64 | List word, byte lane k = byte at address + k |
| tbl_we | output | 1 | Table write strobe |
| tbl_re | output | 1 | Table read strobe (data one cycle later) |
| tbl_addr | output | IDX_W | Table entry index |
| tbl_wdata | output | 64 | Table write data |
| tbl_rdata | input | 64 | Table read data |
| ntf_valid | output | 1 | Entry changed notification |
| ntf_iova | output | 64 | Page-aligned window offset |
| ntf_xlat | output | 64 | Entry value with in-page bits cleared |
| ntf_amask | output | 64 | In-page address mask |
| ntf_perm | output | 2 | Access permission bits |

## Verification
On every cycle the assertions check the handshake rules: an accepted command leads either to a response or to busy, no response arrives while busy is high, list fetches stay 8-byte aligned with only one in flight, and each notification agrees with the table write beside it. Whether the right entry was written with the right value, how the page counts are bounded, how list data is byte-ordered and how a run halts part way are data matters. Only the bench's scenarios can show them, by comparing the table image and each response against a reference model.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int XW      = 64;
  localparam int SHIFT_W = 6;

  typedef enum logic [2:0] {
    OP_STORE = 3'd0,
    OP_READ  = 3'd1,
    OP_FILL  = 3'd2,
    OP_LIST  = 3'd3,
    OP_OPEN  = 3'd4,
    OP_CLOSE = 3'd5
  } xlt_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_STEP,
    ST_FETCH,
    ST_WAITM
  } xlt_state_e;
endpackage

// File: rtl/xlt_locate.sv
module xlt_locate #(
  parameter int AW    = 64,
  parameter int SW    = 6,
  parameter int NUM_W = 11
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    base,
  input  logic [SW-1:0]    shift,
  input  logic [NUM_W-1:0] count,
  output logic [AW-1:0]    mask,
  output logic [AW-1:0]    aligned,
  output logic [AW-1:0]    offset,
  output logic [AW-1:0]    index,
  output logic             hit
);
  logic [AW-1:0] rel;

  always_comb begin
    mask    = ~((AW'(1) << shift) - AW'(1));
    aligned = addr & mask;
    rel     = aligned - base;
    offset  = rel & mask;
    index   = rel >> shift;
    hit     = index < AW'(count);
  end
endmodule

// File: rtl/xlt_swap.sv
module xlt_swap #(
  parameter int BYTES = 8
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign dout[8*(BYTES-1-k) +: 8] = din[8*k +: 8];
  end
endmodule

// File: rtl/xlt_update_engine.sv
module xlt_update_engine
  import xlt_pkg::*;
#(
  parameter logic [31:0] TABLE_ID    = 32'h0000_8001,
  parameter int          MAX_ENTRIES = 1024,
  parameter int          CNT_W       = 32,
  parameter int          LIST_MAX    = 512,
  parameter int          LIST_ALIGN  = 12,
  localparam int         IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [XW-1:0]    cmd_id,
  input  logic [XW-1:0]    cmd_addr,
  input  logic [XW-1:0]    cmd_value,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [XW-1:0]    rsp_value,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [XW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [XW-1:0]    mem_rsp_data,
  output logic             tbl_we,
  output logic             tbl_re,
  output logic [IDX_W-1:0] tbl_addr,
  output logic [XW-1:0]    tbl_wdata,
  input  logic [XW-1:0]    tbl_rdata,
  output logic             ntf_valid,
  output logic [XW-1:0]    ntf_iova,
  output logic [XW-1:0]    ntf_xlat,
  output logic [XW-1:0]    ntf_amask,
  output logic [1:0]       ntf_perm
);
  localparam int NUM_W = IDX_W + 1;

  xlt_state_e        state;
  logic [XW-1:0]     cfg_base;
  logic [SHIFT_W-1:0] cfg_shift;
  logic [NUM_W-1:0]  cfg_count;
  logic [XW-1:0]     cur_addr, list_ptr, val_q;
  logic [CNT_W-1:0]  rem_q;

  xlt_op_e       op;
  logic          id_ok, step_go;
  logic [XW-1:0] c_mask, c_aligned, c_offset, c_index;
  logic [XW-1:0] s_mask, s_aligned, s_offset, s_index;
  logic          c_hit, s_hit;
  logic [XW-1:0] swapped, step_val, psize;

  assign op        = xlt_op_e'(cmd_op);
  assign id_ok     = (cmd_id[XW-1:32] == '0) && (cmd_id[31:0] == TABLE_ID);
  assign busy      = (state != ST_IDLE);
  assign cmd_ready = (state == ST_IDLE);
  assign step_go   = (state == ST_STEP) || (state == ST_WAITM && mem_rsp_valid);
  assign step_val  = (state == ST_WAITM) ? swapped : val_q;
  assign psize     = XW'(1) << cfg_shift;

  xlt_locate #(.AW(XW), .SW(SHIFT_W), .NUM_W(NUM_W)) u_cmd_loc (
    .addr(cmd_addr), .base(cfg_base), .shift(cfg_shift), .count(cfg_count),
    .mask(c_mask), .aligned(c_aligned), .offset(c_offset), .index(c_index), .hit(c_hit)
  );

  xlt_locate #(.AW(XW), .SW(SHIFT_W), .NUM_W(NUM_W)) u_run_loc (
    .addr(cur_addr), .base(cfg_base), .shift(cfg_shift), .count(cfg_count),
    .mask(s_mask), .aligned(s_aligned), .offset(s_offset), .index(s_index), .hit(s_hit)
  );

  xlt_swap #(.BYTES(XW/8)) u_swap (.din(mem_rsp_data), .dout(swapped));

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cfg_base      <= '0;
      cfg_shift     <= '0;
      cfg_count     <= '0;
      cur_addr      <= '0;
      list_ptr      <= '0;
      val_q         <= '0;
      rem_q         <= '0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_value     <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      tbl_we        <= 1'b0;
      tbl_re        <= 1'b0;
      tbl_addr      <= '0;
      tbl_wdata     <= '0;
      ntf_valid     <= 1'b0;
      ntf_iova      <= '0;
      ntf_xlat      <= '0;
      ntf_amask     <= '0;
      ntf_perm      <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      tbl_we        <= 1'b0;
      tbl_re        <= 1'b0;
      ntf_valid     <= 1'b0;
      mem_req_valid <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            // default outcome: parameter error, single-cycle response
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_value <= '0;
            if (id_ok) begin
              case (op)
                OP_STORE: begin
                  if (c_hit) begin
                    rsp_err   <= 1'b0;
                    tbl_we    <= 1'b1;
                    tbl_addr  <= c_index[IDX_W-1:0];
                    tbl_wdata <= cmd_value;
                    ntf_valid <= 1'b1;
                    ntf_iova  <= c_offset;
                    ntf_xlat  <= cmd_value & c_mask;
                    ntf_amask <= ~c_mask;
                    ntf_perm  <= cmd_value[1:0];
                  end
                end
                OP_READ: begin
                  if (c_hit) begin
                    rsp_valid <= 1'b0;
                    tbl_re    <= 1'b1;
                    tbl_addr  <= c_index[IDX_W-1:0];
                    state     <= ST_RD1;
                  end
                end
                OP_FILL: begin
                  if (cmd_count <= CNT_W'(cfg_count)) begin
                    rsp_err <= 1'b0;
                    if (cmd_count != '0) begin
                      rsp_valid <= 1'b0;
                      cur_addr  <= c_aligned;
                      val_q     <= cmd_value;
                      rem_q     <= cmd_count;
                      state     <= ST_STEP;
                    end
                  end
                end
                OP_LIST: begin
                  if (cmd_count <= CNT_W'(LIST_MAX) && cmd_addr[LIST_ALIGN-1:0] == '0) begin
                    rsp_err <= 1'b0;
                    if (cmd_count != '0) begin
                      rsp_valid <= 1'b0;
                      cur_addr  <= c_aligned;
                      list_ptr  <= cmd_addr;
                      rem_q     <= cmd_count;
                      state     <= ST_FETCH;
                    end
                  end
                end
                OP_OPEN: begin
                  if (cfg_count != '0) begin
                    rsp_err <= 1'b0;
                  end else if (cmd_count != '0 && cmd_count <= CNT_W'(MAX_ENTRIES)) begin
                    rsp_err   <= 1'b0;
                    cfg_base  <= cmd_addr;
                    cfg_shift <= cmd_value[SHIFT_W-1:0];
                    cfg_count <= NUM_W'(cmd_count);
                  end
                end
                OP_CLOSE: begin
                  rsp_err   <= 1'b0;
                  cfg_base  <= '0;
                  cfg_shift <= '0;
                  cfg_count <= '0;
                end
                default: ;
              endcase
            end
          end
        end
        ST_RD1: state <= ST_RD2;
        ST_RD2: begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_value <= tbl_rdata;
          state     <= ST_IDLE;
        end
        ST_FETCH: begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= list_ptr;
          list_ptr      <= list_ptr + XW'(8);
          state         <= ST_WAITM;
        end
        default: ;
      endcase

      if (step_go) begin
        if (!s_hit) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_value <= '0;
          state     <= ST_IDLE;
        end else begin
          tbl_we    <= 1'b1;
          tbl_addr  <= s_index[IDX_W-1:0];
          tbl_wdata <= step_val;
          ntf_valid <= 1'b1;
          ntf_iova  <= s_offset;
          ntf_xlat  <= step_val & s_mask;
          ntf_amask <= ~s_mask;
          ntf_perm  <= step_val[1:0];
          cur_addr  <= cur_addr + psize;
          rem_q     <= rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_value <= '0;
            state     <= ST_IDLE;
          end else if (state == ST_WAITM) begin
            state <= ST_FETCH;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             busy,
  input logic             rsp_valid,
  input logic             mem_req_valid,
  input logic [63:0]      mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             tbl_we,
  input logic             tbl_re,
  input logic [63:0]      tbl_wdata,
  input logic             ntf_valid,
  input logic [63:0]      ntf_iova,
  input logic [63:0]      ntf_xlat,
  input logic [63:0]      ntf_amask,
  input logic [1:0]       ntf_perm
);
  logic outst;

  always_ff @(posedge clk) begin
    if (rst)                outst <= 1'b0;
    else if (mem_req_valid) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  // R11: an accepted command either responds or goes busy
  assert_accept_progress_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (rsp_valid || busy));

  // R11: a response is only given once the engine is idle again
  assert_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  // R8: one list fetch in flight at most
  assert_single_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outst);

  // R8: list words are fetched on 8-byte boundaries
  assert_fetch_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

  // R4: notification accompanies a write and its fields are consistent with it
  assert_ntf_fields_R4: assert property (@(posedge clk) disable iff (rst)
    ntf_valid |-> (tbl_we && (ntf_xlat & ntf_amask) == 64'd0 &&
                   (ntf_iova & ntf_amask) == 64'd0 && ntf_perm == tbl_wdata[1:0]));

  // R5: table read and write never share a cycle
  assert_port_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(tbl_we && tbl_re));
endmodule

bind xlt_update_engine xlt_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .busy(busy),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_wdata(tbl_wdata),
  .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
  .ntf_amask(ntf_amask), .ntf_perm(ntf_perm)
);

// File: tb/xlt_update_engine_tb.sv
module xlt_update_engine_tb;
  localparam logic [31:0] TID  = 32'h0000_8001;
  localparam int          MAXE = 1024;
  localparam int          IW   = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [63:0] cmd_id = '0, cmd_addr = '0, cmd_value = '0;
  logic [31:0] cmd_count = '0;
  logic        rsp_valid, rsp_err, busy;
  logic [63:0] rsp_value;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        tbl_we, tbl_re;
  logic [IW-1:0] tbl_addr;
  logic [63:0] tbl_wdata, tbl_rdata;
  logic        ntf_valid;
  logic [63:0] ntf_iova, ntf_xlat, ntf_amask;
  logic [1:0]  ntf_perm;

  always #2 clk = ~clk;

  xlt_update_engine #(.TABLE_ID(TID), .MAX_ENTRIES(MAXE)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_addr(cmd_addr), .cmd_value(cmd_value), .cmd_count(cmd_count),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_value(rsp_value), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_rdata(tbl_rdata), .ntf_valid(ntf_valid), .ntf_iova(ntf_iova), .ntf_xlat(ntf_xlat),
    .ntf_amask(ntf_amask), .ntf_perm(ntf_perm)
  );

  // table storage seen by the engine
  logic [63:0] tbl_mem [MAXE];
  logic [63:0] ref_tbl [MAXE];
  always @(posedge clk) begin
    if (tbl_we) tbl_mem[tbl_addr] <= tbl_wdata;
    if (tbl_re) tbl_rdata <= tbl_mem[tbl_addr];
  end

  // list memory: byte at address a is a fixed function of a
  function automatic logic [7:0] lbyte(input logic [63:0] a);
    return 8'(a * 64'd37 + (a >> 8));
  endfunction
  function automatic logic [63:0] list_word(input logic [63:0] a);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++) w = {w[55:0], lbyte(a + 64'(k))};
    return w;
  endfunction

  logic        pend = 1'b0;
  logic [63:0] pend_addr = '0;
  int          pend_dly = 0;
  int          n_fetch = 0;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      pend_dly  <= int'($urandom % 3);
      n_fetch   <= n_fetch + 1;
    end else if (pend) begin
      if (pend_dly == 0) begin
        mem_rsp_valid <= 1'b1;
        for (int k = 0; k < 8; k++) mem_rsp_data[8*k +: 8] <= lbyte(pend_addr + 64'(k));
        pend <= 1'b0;
      end else pend_dly <= pend_dly - 1;
    end
  end

  logic [63:0] last_iova, last_xlat, last_amask;
  logic [1:0]  last_perm;
  always @(posedge clk) if (ntf_valid) begin
    last_iova <= ntf_iova; last_xlat <= ntf_xlat; last_amask <= ntf_amask; last_perm <= ntf_perm;
  end

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [63:0] m_base = '0;
  int          m_shift = 0;
  int          m_cnt = 0;

  task automatic model(input logic [2:0] op, input logic [63:0] id, addr, val,
                       input logic [31:0] cnt, output logic e_err, output logic [63:0] e_val);
    logic [63:0] mask, al, a, ix, v;
    e_err = 1'b1; e_val = '0;
    mask = ~((64'd1 << m_shift) - 64'd1);
    al   = addr & mask;
    ix   = (al - m_base) >> m_shift;
    if (id[63:32] != 0 || id[31:0] != TID) return;
    case (op)
      3'd0: if (ix < 64'(m_cnt)) begin ref_tbl[ix] = val; e_err = 1'b0; end
      3'd1: if (ix < 64'(m_cnt)) begin e_val = ref_tbl[ix]; e_err = 1'b0; end
      3'd2, 3'd3: begin
        if ((op == 3'd2 && cnt <= 32'(m_cnt)) ||
            (op == 3'd3 && cnt <= 32'd512 && addr[11:0] == 12'd0)) begin
          e_err = 1'b0;
          for (int i = 0; i < int'(cnt); i++) begin
            a  = al + (64'(i) << m_shift);
            ix = (a - m_base) >> m_shift;
            v  = (op == 3'd2) ? val : list_word(addr + 64'(8 * i));
            if (ix >= 64'(m_cnt)) begin e_err = 1'b1; break; end
            ref_tbl[ix] = v;
          end
        end
      end
      3'd4: begin
        if (m_cnt != 0) e_err = 1'b0;
        else if (cnt != 0 && cnt <= 32'(MAXE)) begin
          m_base = addr; m_shift = int'(val[5:0]); m_cnt = int'(cnt); e_err = 1'b0;
        end
      end
      3'd5: begin m_base = '0; m_shift = 0; m_cnt = 0; e_err = 1'b0; end
      default: ;
    endcase
  endtask

  logic        busy_seen;
  int          rsp_lat;
  task automatic do_cmd(input logic [2:0] op, input logic [63:0] id, addr, val,
                        input logic [31:0] cnt, output logic a_err, output logic [63:0] a_val);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_addr = addr; cmd_value = val; cmd_count = cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_seen = busy && !cmd_ready;
    rsp_lat = 1;
    while (!rsp_valid) begin @(negedge clk); rsp_lat++; end
    a_err = rsp_err; a_val = rsp_value;
    @(negedge clk);
  endtask

  task automatic run(input logic [2:0] op, input logic [63:0] id, addr, val,
                     input logic [31:0] cnt, input string req);
    logic e_err, a_err;
    logic [63:0] e_val, a_val;
    model(op, id, addr, val, cnt, e_err, e_val);
    do_cmd(op, id, addr, val, cnt, a_err, a_val);
    chk(a_err == e_err, req, "status", 64'(a_err), 64'(e_err));
    if (op == 3'd1) chk(a_val == e_val, req, "read value", a_val, e_val);
  endtask

  task automatic tbl_compare(input string req);
    int bad = 0;
    for (int i = 0; i < MAXE; i++) if (tbl_mem[i] !== ref_tbl[i]) begin
      if (bad == 0) chk(1'b0, req, $sformatf("table entry %0d", i), tbl_mem[i], ref_tbl[i]);
      bad++;
    end
    if (bad == 0) chk(1'b1, req, "table image", 0, 0);
  endtask

  localparam logic [63:0] ID   = {32'd0, TID};
  localparam logic [63:0] BASE = 64'h0001_0000;

  initial begin
    logic [63:0] addr, val;
    logic [31:0] cnt;
    logic [2:0]  op;
    int f0;
    void'($urandom(32'd2024));
    for (int i = 0; i < MAXE; i++) begin tbl_mem[i] = '0; ref_tbl[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !busy && cmd_ready && !tbl_we && !tbl_re && !mem_req_valid && !ntf_valid,
        "R12", "idle after reset", {59'd0, rsp_valid, busy, tbl_we, mem_req_valid, ntf_valid}, 0);
    // R3: closed window rejects a store
    run(3'd0, ID, BASE, 64'h1234, 0, "R3");
    // R10: open, then a second open is ignored
    run(3'd4, ID, BASE, 64'd12, 64, "R10");
    run(3'd4, ID, 64'h0, 64'd16, 128, "R10");
    run(3'd0, ID, BASE + 64'(64 << 12), 64'h55, 0, "R10");
    run(3'd0, ID, BASE + 64'(63 << 12), 64'h57, 0, "R10");
    // R1: identifier checks
    run(3'd0, ID | 64'h1_0000_0000, BASE, 64'h99, 0, "R1");
    run(3'd0, ID ^ 64'h1, BASE, 64'h99, 0, "R1");
    // R2 and R4: unaligned store, notification fields, one-cycle response
    run(3'd0, ID, BASE + 64'h3123, 64'hABCD_E000_0000_7003, 0, "R2");
    chk(rsp_lat == 1, "R2", "store latency", 64'(rsp_lat), 1);
    chk(last_iova == 64'h3000, "R4", "iova", last_iova, 64'h3000);
    chk(last_xlat == 64'hABCD_E000_0000_7000, "R4", "xlat", last_xlat, 64'hABCD_E000_0000_7000);
    chk(last_amask == 64'hFFF, "R4", "amask", last_amask, 64'hFFF);
    chk(last_perm == 2'd3, "R4", "perm", 64'(last_perm), 3);
    run(3'd0, ID, BASE + 64'h4000, 64'h0000_0000_0009_1001, 0, "R4");
    chk(last_perm == 2'd1, "R4", "perm read-only", 64'(last_perm), 1);
    // R5: read back and out-of-range read
    run(3'd1, ID, BASE + 64'h3FFF, 0, 0, "R5");
    chk(rsp_lat == 3, "R5", "read latency", 64'(rsp_lat), 3);
    run(3'd1, ID, BASE + 64'(70 << 12), 0, 0, "R5");
    // R3: address below base
    run(3'd0, ID, BASE - 64'h1000, 64'h77, 0, "R3");
    // R6: fill bounds and a normal run; R11 busy
    run(3'd2, ID, BASE, 64'h66, 65, "R6");
    run(3'd2, ID, BASE + 64'(10 << 12), 64'hF0F0_0002, 4, "R6");
    chk(busy_seen, "R11", "busy and not ready during fill", 64'(busy_seen), 1);
    run(3'd2, ID, BASE, 64'h66, 0, "R6");
    // R9: fill running off the end keeps earlier entries
    run(3'd2, ID, BASE + 64'(62 << 12), 64'h1111_2003, 4, "R9");
    tbl_compare("R9");
    // R7: list limits
    f0 = n_fetch;
    run(3'd3, ID, 64'h20_0000, 0, 513, "R7");
    run(3'd3, ID, 64'h20_0008, 0, 2, "R7");
    chk(n_fetch == f0, "R7", "no fetch on rejected list", 64'(n_fetch), 64'(f0));
    // R8: list with byte order
    run(3'd3, ID, BASE + 64'(20 << 12), 64'h0, 3, "R8");
    // the list address is the command address, so use a separate call
    run(3'd3, ID, 64'h0003_0000, 0, 3, "R8");
    tbl_compare("R8");
    chk(n_fetch == f0 + 6, "R8", "fetch count", 64'(n_fetch), 64'(f0 + 6));
    // R9: list running off the end
    run(3'd3, ID, 64'h0007_F000, 0, 5, "R9");
    tbl_compare("R9");
    // R10: close then store rejected, reopen with 64 KiB pages
    run(3'd5, ID, 0, 0, 0, "R10");
    run(3'd0, ID, BASE, 64'h42, 0, "R10");
    run(3'd4, ID, 64'h0, 64'd16, 64, "R10");
    run(3'd0, ID, 64'h0002_1234, 64'h0000_0000_0005_0002, 0, "R10");
    chk(last_amask == 64'hFFFF && last_iova == 64'h2_0000, "R10", "64 KiB page fields",
        last_amask, 64'hFFFF);
    run(3'd5, ID, 0, 0, 0, "R10");
    run(3'd4, ID, BASE, 64'd12, 64, "R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      op   = 3'($urandom % 4);
      addr = BASE + (64'($urandom % 72) << 12) + 64'($urandom % 4096);
      if ($urandom % 12 == 0) addr = BASE - 64'h1000;
      val  = {$urandom, $urandom};
      cnt  = 32'($urandom % 9);
      if (op == 3'd2 && $urandom % 10 == 0) cnt = 32'd65 + 32'($urandom % 3);
      if (op == 3'd3) begin
        addr = 64'h0001_0000 + (64'($urandom % 70) << 12);
        if ($urandom % 10 == 0) addr = addr + 64'h8;
        if ($urandom % 15 == 0) cnt = 32'd513;
      end
      run(op, ($urandom % 20 == 0) ? (ID ^ 64'h2) : ID, addr, val, cnt,
          op == 3'd0 ? "R2" : op == 3'd1 ? "R5" : op == 3'd2 ? "R6" : "R8");
    end
    tbl_compare("R9");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule